// File: doc/BRIEF.md
# Register Sidecar Bounds Checker

This block keeps a small region cache next to each address-base register of a pipeline. Each cache slot holds the lower limit, the exclusive upper limit and the access rights of the last region that an address built from that register fell in. When a memory access arrives, the block adds a sign-extended immediate to the base register value. It then tests the sum against the slot attached to that register. If the slot is valid, the sum lies inside the region, and the rights allow the operation, the access completes at once and the protection lookaside buffer is not consulted.

If any of these conditions fails, the block asks the lookaside buffer for the region that covers the address. It stalls until the answer arrives, writes that answer into the slot, and then reports the access with a fault flag that comes from the returned rights. Regions can be any word-aligned span, so they need not be a power of two in size. A write to an architectural register clears that register's slot. A protection-domain change clears every slot.

Top module: `sidecar_checker`

## Requirements
- R1: After reset every slot is invalid, `ready` is 1, and `lkp_req_valid` and `done_valid` are 0.
- R2: The effective address is the base register value plus the 12-bit immediate sign-extended to 32 bits, taken modulo 2^32. It appears on `done_addr` and on `lkp_req_addr`.
- R3: An accepted access is a hit when the selected slot is valid, `lo <= ea < hi` holds under unsigned comparison, and the slot's rights allow the operation. On a hit, `done_valid` and `done_hit` are 1 in the cycle after acceptance, `done_fault` is 0, and no lookup is requested.
- R4: The rights codes are 0 none, 1 read-only, 2 read-write and 3 read-execute. The operation codes are 0 read, 1 write and 2 execute; code 3 is never allowed. Read-only allows read. Read-write allows read and write. Read-execute allows read and execute.
- R5: On a miss, in the cycle after acceptance, `lkp_req_valid` is 1 with the effective address and the operation code, and `ready` is 0. Both stay unchanged until `lkp_rsp_valid`.
- R6: In the cycle a response arrives, the slot of the pending register is loaded with the returned lo, hi and rights. In the next cycle `done_valid` is 1, `done_hit` is 0, `lkp_req_valid` is 0, and `done_fault` is 1 exactly when the returned rights deny the operation.
- R7: A pulse on `reg_wr_valid` invalidates only the slot named by `reg_wr_idx`. Slots for other registers keep hitting.
- R8: A pulse on `domain_switch` invalidates all slots.
- R9: An access that is in range but whose operation is denied by the slot's rights is treated as a miss, not as a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access offered; taken when `ready` is 1 |
| acc_idx | input | 3 | Base register index |
| acc_base | input | 32 | Base register value |
| acc_imm | input | 12 | Signed immediate offset |
| acc_op | input | 2 | Operation code (R4) |
| ready | output | 1 | Block can accept an access |
| done_valid | output | 1 | Access result valid for one cycle |
| done_hit | output | 1 | Result came from a slot without lookup |
| done_fault | output | 1 | Operation denied |
| done_addr | output | 32 | Effective address of the result |
| lkp_req_valid | output | 1 | Lookup request to the lookaside buffer |
| lkp_req_addr | output | 32 | Address to look up |
| lkp_req_op | output | 2 | Operation of the pending access |
| lkp_rsp_valid | input | 1 | Lookup answer valid |
| lkp_rsp_lo | input | 32 | Region lower limit (inclusive) |
| lkp_rsp_hi | input | 32 | Region upper limit (exclusive) |
| lkp_rsp_perm | input | 2 | Region rights (R4) |
| reg_wr_valid | input | 1 | Architectural register written |
| reg_wr_idx | input | 3 | Index of the written register |
| domain_switch | input | 1 | Protection domain changed |

## Verification
The bench uses the default parameters: 32-bit addresses, eight slots and a 12-bit immediate. The 3-bit index lets random traffic reach every slot, and it lets an invalidation of one register be checked against the survival of the other seven. With a 12-bit signed immediate, negative offsets can move an address below a region's lower limit from a base inside it. The model's 48-byte regions, which are not a power of two in size, put both the inclusive lower edge and the exclusive upper edge within reach of the directed probes.

// File: rtl/sc_pkg.sv
package sc_pkg;

    parameter int unsigned SC_AW = 32;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RO   = 2'd1,
        PERM_RW   = 2'd2,
        PERM_RX   = 2'd3
    } perm_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EXEC  = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } state_e;

    typedef struct packed {
        logic              valid;
        logic [SC_AW-1:0]  lo;
        logic [SC_AW-1:0]  hi;
        perm_e             perm;
    } slot_t;

    // R4: rights table
    function automatic logic perm_allows(perm_e p, op_e o);
        case (p)
            PERM_RO: return (o == OP_READ);
            PERM_RW: return (o == OP_READ) || (o == OP_WRITE);
            PERM_RX: return (o == OP_READ) || (o == OP_EXEC);
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sc_addr_gen.sv
module sc_addr_gen #(
    parameter int unsigned AW    = 32,
    parameter int unsigned IMM_W = 12
) (
    input  logic [AW-1:0]    base,
    input  logic [IMM_W-1:0] imm,
    output logic [AW-1:0]    ea
);
    localparam int unsigned EXT_W = AW - IMM_W;

    logic [AW-1:0] imm_ext;

    // R2: sign extension then modular add
    assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign ea      = base + imm_ext;

endmodule

// File: rtl/sc_match.sv
module sc_match
    import sc_pkg::*;
(
    input  slot_t             slot,
    input  logic [SC_AW-1:0]  ea,
    input  op_e               op,
    output logic              hit
);
    logic above_lo;
    logic below_hi;
    logic rights_ok;

    // R3: half-open unsigned range, R9: rights must also allow
    always_comb begin
        above_lo  = (ea >= slot.lo);
        below_hi  = (ea <  slot.hi);
        rights_ok = perm_allows(slot.perm, op);
        hit       = slot.valid && above_lo && below_hi && rights_ok;
    end

endmodule

// File: rtl/sc_store.sv
module sc_store
    import sc_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 8,
    localparam int unsigned IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output slot_t             rd_slot,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SC_AW-1:0]  wr_lo,
    input  logic [SC_AW-1:0]  wr_hi,
    input  perm_e             wr_perm,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx,
    input  logic              flush
);
    slot_t                slots [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] valid_vec;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                slots[g].valid <= 1'b0;
                slots[g].lo    <= '0;
                slots[g].hi    <= '0;
                slots[g].perm  <= PERM_NONE;
            end else if (inv_en && (inv_idx == IDX_W'(g))) begin
                slots[g].valid <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slots[g].valid <= 1'b1;
                slots[g].lo    <= wr_lo;
                slots[g].hi    <= wr_hi;
                slots[g].perm  <= wr_perm;
            end
        end
        assign valid_vec[g] = slots[g].valid;
    end

    assign rd_slot = slots[rd_idx];

    // R8: a domain change leaves no slot valid
    a_r8_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0));

    // R7: the named slot is invalid after a register write
    a_r7_inv_clears: assert property (@(posedge clk) disable iff (rst)
        inv_en |=> !valid_vec[$past(inv_idx)]);

    // R6: a refill not overridden makes its slot valid
    a_r6_refill_sets: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush && !(inv_en && inv_idx == wr_idx)) |=> valid_vec[$past(wr_idx)]);

endmodule

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import sc_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 8,
    localparam int unsigned IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [SC_AW-1:0]  ea,
    input  op_e               op,
    input  logic              hit,
    input  logic              rsp_valid,
    input  perm_e             rsp_perm,
    output logic              ready,
    output logic              req_valid,
    output logic [SC_AW-1:0]  req_addr,
    output op_e               req_op,
    output logic [IDX_W-1:0]  pend_idx,
    output logic              refill_en,
    output logic              done_valid,
    output logic              done_hit,
    output logic              done_fault,
    output logic [SC_AW-1:0]  done_addr
);
    state_e state;

    assign ready     = (state == ST_IDLE);
    assign refill_en = (state == ST_WAIT) && rsp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            req_valid  <= 1'b0;
            req_addr   <= '0;
            req_op     <= OP_READ;
            pend_idx   <= '0;
            done_valid <= 1'b0;
            done_hit   <= 1'b0;
            done_fault <= 1'b0;
            done_addr  <= '0;
        end else begin
            done_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (acc_valid) begin
                        if (hit) begin
                            done_valid <= 1'b1;
                            done_hit   <= 1'b1;
                            done_fault <= 1'b0;
                            done_addr  <= ea;
                        end else begin
                            state     <= ST_WAIT;
                            req_valid <= 1'b1;
                            req_addr  <= ea;
                            req_op    <= op;
                            pend_idx  <= acc_idx;
                        end
                    end
                end
                ST_WAIT: begin
                    if (rsp_valid) begin
                        state      <= ST_IDLE;
                        req_valid  <= 1'b0;
                        done_valid <= 1'b1;
                        done_hit   <= 1'b0;
                        done_fault <= !perm_allows(rsp_perm, req_op);
                        done_addr  <= req_addr;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: request held with stable address until answered
    a_r5_req_held: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rsp_valid) |=> (req_valid && $stable(req_addr) && $stable(req_op)));

    // R5: no new access is taken while a lookup is outstanding
    a_r5_ready_excl: assert property (@(posedge clk) disable iff (rst)
        !(ready && req_valid));

    // R3: a hit never carries a fault
    a_r3_hit_no_fault: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_hit) |-> !done_fault);

    // R6: an answer ends the request on the next cycle
    a_r6_rsp_done: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rsp_valid) |=> (done_valid && !done_hit && !req_valid));

endmodule

// File: rtl/sidecar_checker.sv
module sidecar_checker
    import sc_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned IMM_W     = 12,
    localparam int unsigned IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [SC_AW-1:0]  acc_base,
    input  logic [IMM_W-1:0]  acc_imm,
    input  logic [1:0]        acc_op,
    output logic              ready,
    output logic              done_valid,
    output logic              done_hit,
    output logic              done_fault,
    output logic [SC_AW-1:0]  done_addr,
    output logic              lkp_req_valid,
    output logic [SC_AW-1:0]  lkp_req_addr,
    output logic [1:0]        lkp_req_op,
    input  logic              lkp_rsp_valid,
    input  logic [SC_AW-1:0]  lkp_rsp_lo,
    input  logic [SC_AW-1:0]  lkp_rsp_hi,
    input  logic [1:0]        lkp_rsp_perm,
    input  logic              reg_wr_valid,
    input  logic [IDX_W-1:0]  reg_wr_idx,
    input  logic              domain_switch
);
    logic [SC_AW-1:0] ea;
    slot_t            cur_slot;
    logic             hit;
    op_e              op_in;
    perm_e            rsp_perm;
    op_e              req_op;
    logic [IDX_W-1:0] pend_idx;
    logic             refill_en;

    assign op_in      = op_e'(acc_op);
    assign rsp_perm   = perm_e'(lkp_rsp_perm);
    assign lkp_req_op = req_op;

    sc_addr_gen #(.AW(SC_AW), .IMM_W(IMM_W)) u_agen (
        .base (acc_base),
        .imm  (acc_imm),
        .ea   (ea)
    );

    sc_store #(.NUM_SLOTS(NUM_SLOTS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (acc_idx),
        .rd_slot (cur_slot),
        .wr_en   (refill_en),
        .wr_idx  (pend_idx),
        .wr_lo   (lkp_rsp_lo),
        .wr_hi   (lkp_rsp_hi),
        .wr_perm (rsp_perm),
        .inv_en  (reg_wr_valid),
        .inv_idx (reg_wr_idx),
        .flush   (domain_switch)
    );

    sc_match u_match (
        .slot (cur_slot),
        .ea   (ea),
        .op   (op_in),
        .hit  (hit)
    );

    sc_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .acc_valid  (acc_valid),
        .acc_idx    (acc_idx),
        .ea         (ea),
        .op         (op_in),
        .hit        (hit),
        .rsp_valid  (lkp_rsp_valid),
        .rsp_perm   (rsp_perm),
        .ready      (ready),
        .req_valid  (lkp_req_valid),
        .req_addr   (lkp_req_addr),
        .req_op     (req_op),
        .pend_idx   (pend_idx),
        .refill_en  (refill_en),
        .done_valid (done_valid),
        .done_hit   (done_hit),
        .done_fault (done_fault),
        .done_addr  (done_addr)
    );

    // R2: request and result carry the same effective address
    a_r2_addr_carried: assert property (@(posedge clk) disable iff (rst)
        (lkp_req_valid && lkp_rsp_valid) |=> (done_addr == $past(lkp_req_addr)));

endmodule

// File: tb/sidecar_checker_tb_top.sv
module sidecar_checker_tb_top;

    localparam int NS = 8;
    localparam int RSZ = 48;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid;
    logic [2:0]  acc_idx;
    logic [31:0] acc_base;
    logic [11:0] acc_imm;
    logic [1:0]  acc_op;
    logic        ready, done_valid, done_hit, done_fault;
    logic [31:0] done_addr;
    logic        lkp_req_valid;
    logic [31:0] lkp_req_addr;
    logic [1:0]  lkp_req_op;
    logic        lkp_rsp_valid;
    logic [31:0] lkp_rsp_lo, lkp_rsp_hi;
    logic [1:0]  lkp_rsp_perm;
    logic        reg_wr_valid;
    logic [2:0]  reg_wr_idx;
    logic        domain_switch;

    int n_checks = 0;
    int n_fail   = 0;

    logic        m_valid [NS];
    logic [31:0] m_lo    [NS];
    logic [31:0] m_hi    [NS];
    logic [1:0]  m_perm  [NS];

    always #2.5 clk = ~clk;

    sidecar_checker dut_i (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_idx(acc_idx), .acc_base(acc_base),
        .acc_imm(acc_imm), .acc_op(acc_op),
        .ready(ready), .done_valid(done_valid), .done_hit(done_hit),
        .done_fault(done_fault), .done_addr(done_addr),
        .lkp_req_valid(lkp_req_valid), .lkp_req_addr(lkp_req_addr),
        .lkp_req_op(lkp_req_op), .lkp_rsp_valid(lkp_rsp_valid),
        .lkp_rsp_lo(lkp_rsp_lo), .lkp_rsp_hi(lkp_rsp_hi),
        .lkp_rsp_perm(lkp_rsp_perm), .reg_wr_valid(reg_wr_valid),
        .reg_wr_idx(reg_wr_idx), .domain_switch(domain_switch)
    );

    function automatic bit allows(logic [1:0] p, logic [1:0] o);
        if (o == 2'd3) return 1'b0;
        if (p == 2'd1) return o == 2'd0;
        if (p == 2'd2) return o != 2'd2;
        if (p == 2'd3) return o != 2'd1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] calc_ea(logic [31:0] b, logic [11:0] i);
        int signed off;
        off = (i >= 12'h800) ? int'(i) - 4096 : int'(i);
        return b + 32'(off);
    endfunction

    function automatic logic [31:0] reg_lo(logic [31:0] a);
        return (a / RSZ) * RSZ;
    endfunction

    function automatic logic [1:0] reg_perm(logic [31:0] a);
        return 2'((a / RSZ) % 4);
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(int idx, logic [31:0] bv, logic [11:0] imm, logic [1:0] op, int dly);
        logic [31:0] ea;
        bit          exp_hit;
        logic [31:0] lo;
        logic [1:0]  pm;
        ea = calc_ea(bv, imm);
        exp_hit = m_valid[idx] && (ea >= m_lo[idx]) && (ea < m_hi[idx]) && allows(m_perm[idx], op);
        @(negedge clk);
        acc_valid = 1'b1; acc_idx = 3'(idx); acc_base = bv; acc_imm = imm; acc_op = op;
        @(negedge clk);
        acc_valid = 1'b0;
        if (exp_hit) begin
            check(done_valid && done_hit && !done_fault, "R3 hit", {29'd0, done_valid, done_hit, done_fault}, 32'h6);
            check(done_addr == ea, "R2 hit addr", done_addr, ea);
            check(!lkp_req_valid, "R3 no lookup", {31'd0, lkp_req_valid}, 0);
        end else begin
            check(lkp_req_valid && !ready && !done_valid, "R5 miss request", {30'd0, lkp_req_valid, ready}, 32'h2);
            check(lkp_req_addr == ea, "R2 request addr", lkp_req_addr, ea);
            check(lkp_req_op == op, "R5 request op", {30'd0, lkp_req_op}, {30'd0, op});
            for (int k = 0; k < dly; k++) begin
                @(negedge clk);
                check(lkp_req_valid && !ready && lkp_req_addr == ea, "R5 request held", lkp_req_addr, ea);
            end
            lo = reg_lo(ea);
            pm = reg_perm(ea);
            lkp_rsp_valid = 1'b1; lkp_rsp_lo = lo; lkp_rsp_hi = lo + RSZ; lkp_rsp_perm = pm;
            @(negedge clk);
            lkp_rsp_valid = 1'b0;
            check(done_valid && !done_hit && !lkp_req_valid, "R6 refill done", {29'd0, done_valid, done_hit, lkp_req_valid}, 32'h4);
            check(done_fault == !allows(pm, op), "R6 R4 fault", {31'd0, done_fault}, {31'd0, !allows(pm, op)});
            check(done_addr == ea, "R2 done addr", done_addr, ea);
            m_valid[idx] = 1'b1; m_lo[idx] = lo; m_hi[idx] = lo + RSZ; m_perm[idx] = pm;
        end
    endtask

    task automatic reg_write(int idx);
        @(negedge clk);
        reg_wr_valid = 1'b1; reg_wr_idx = 3'(idx);
        @(negedge clk);
        reg_wr_valid = 1'b0;
        m_valid[idx] = 1'b0;
    endtask

    task automatic dom_switch();
        @(negedge clk);
        domain_switch = 1'b1;
        @(negedge clk);
        domain_switch = 1'b0;
        for (int i = 0; i < NS; i++) m_valid[i] = 1'b0;
    endtask

    task automatic expect_hit(int idx, logic [31:0] bv, logic [11:0] imm, logic [1:0] op, bit h, string req);
        logic [31:0] ea;
        bit mh;
        ea = calc_ea(bv, imm);
        mh = m_valid[idx] && (ea >= m_lo[idx]) && (ea < m_hi[idx]) && allows(m_perm[idx], op);
        check(mh == h, req, {31'd0, mh}, {31'd0, h});
        access(idx, bv, imm, op, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd4242;
        void'($urandom(seed));
        acc_valid = 0; acc_idx = 0; acc_base = 0; acc_imm = 0; acc_op = 0;
        lkp_rsp_valid = 0; lkp_rsp_lo = 0; lkp_rsp_hi = 0; lkp_rsp_perm = 0;
        reg_wr_valid = 0; reg_wr_idx = 0; domain_switch = 0;
        for (int i = 0; i < NS; i++) begin
            m_valid[i] = 0; m_lo[i] = 0; m_hi[i] = 0; m_perm[i] = 0;
        end
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ready && !lkp_req_valid && !done_valid, "R1 reset outputs", {29'd0, ready, lkp_req_valid, done_valid}, 32'h4);

        // R1: first use of each register misses
        access(1, 32'd96, 12'd8, 2'd0, 1);
        // region 96..143 perm 2 (RW): R3 edges
        expect_hit(1, 32'd96, 12'd0, 2'd1, 1'b1, "R3 lower edge inclusive");
        expect_hit(1, 32'd96, 12'd44, 2'd0, 1'b1, "R3 last word");
        expect_hit(1, 32'd96, 12'd48, 2'd0, 1'b0, "R3 upper edge exclusive");
        // reg 1 now holds 144..191 perm 3 (RX)
        expect_hit(1, 32'd150, 12'hFFA, 2'd2, 1'b1, "R2 negative imm hit");
        expect_hit(1, 32'd150, 12'hFF6, 2'd0, 1'b0, "R3 below lower edge");
        // reg 1 holds 96..143 RW; R9 exec denied in range -> miss
        expect_hit(1, 32'd100, 12'd0, 2'd2, 1'b0, "R9 denied op misses");
        // R4 reserved op never allowed
        access(2, 32'd0, 12'd4, 2'd3, 0);
        expect_hit(2, 32'd0, 12'd8, 2'd0, 1'b0, "R4 none rights miss");

        // R7: invalidate one register, another survives
        access(3, 32'd48, 12'd0, 2'd0, 0);
        access(4, 32'd240, 12'd0, 2'd0, 2);
        reg_write(3);
        expect_hit(3, 32'd48, 12'd0, 2'd0, 1'b0, "R7 written reg misses");
        expect_hit(4, 32'd240, 12'd4, 2'd0, 1'b1, "R7 other reg hits");

        // R8: domain switch invalidates all
        dom_switch();
        expect_hit(4, 32'd240, 12'd4, 2'd0, 1'b0, "R8 flush miss 4");
        expect_hit(3, 32'd48, 12'd4, 2'd0, 1'b0, "R8 flush miss 3");

        // random mix
        for (int it = 0; it < 400; it++) begin
            int r;
            r = int'($urandom % 20);
            if (r == 0) dom_switch();
            else if (r < 3) reg_write(int'($urandom % NS));
            else begin
                logic [31:0] bv;
                logic [11:0] im;
                bv = ($urandom % 800) & 32'hFFFF_FFFC;
                im = 12'(($urandom % 64) * 4 - 96);
                access(int'($urandom % NS), bv, im, 2'($urandom % 4), int'($urandom % 3));
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule